// File: doc/BRIEF.md
# SD Card SPI Initialization Sequencer

This block takes a flash memory card from power-up to a ready state in SPI mode. A supervising controller pulses `start`. The block then drives the serial link itself through chip select, serial clock and master-out, and it samples master-in.

The bring-up runs in a fixed order:

1. Wake-up clocks are sent with chip select released.
2. A reset command is sent.
3. An interface-condition command is sent. Its answer tells a version-2 high-capacity card from an older card.
4. An application-command / operating-condition pair is sent, and repeated while the card reports that it is still idle.
5. The operating-condition register is read to learn the addressing mode.
6. The block length is set to 512 bytes.

Each response byte is polled within a bounded window and checked against the value the step expects. A hard limit on the number of retries stops a card that never becomes ready.

On success the block holds `done` high and reports the addressing mode on `block_addr`. On any protocol error, missing response or exhausted retry budget it holds `fail` high instead. Both flags stay until the next `start`, and a new `start` reruns the whole sequence from the wake-up clocks.

The state machine has these states:

- `S_IDLE`: wait for `start`.
- `S_WAKE`: send filler bytes with chip select high.
- `S_SEND`: send the six bytes of a command frame.
- `S_POLL`: send filler bytes and wait for a response byte.
- `S_TRAIL`: read the four bytes that follow some responses.
- `S_GAP`: send one filler byte with chip select high.
- `S_DONE`: the sequence finished.
- `S_FAIL`: the sequence failed.

A step register names the command in flight: `C_RESET`, `C_IFCOND`, `C_APPCMD`, `C_OPCOND`, `C_READOCR`, `C_BLKLEN`, and `C_FINISH` after the last step.

The transitions are:

- IDLE, DONE or FAIL go to WAKE on `start`.
- WAKE goes to SEND after its last filler byte.
- SEND goes to POLL after the checksum byte.
- POLL goes to TRAIL, GAP or FAIL on a response byte, and to FAIL when the window runs out.
- TRAIL goes to GAP or FAIL after four bytes.
- GAP goes to SEND, or to DONE when the step is `C_FINISH`.

Top module: `sdspi_init_seq`

## Requirements
- R1: After `start`, chip select stays high and master-out stays high for at least 74 serial clock rising edges before chip select first falls. Master-out is high whenever chip select is high.
- R2: Each command is a 6-byte frame. The first byte is 0x40 OR the command index. The next four bytes are the 32-bit argument, most significant byte first. The last byte is the checksum. The reset command (index 0) uses checksum 0x95, and the interface-condition command (index 8) uses argument 0x000001AA and checksum 0x87.
- R3: Commands are issued in the order 0, 8, then the pair 55/41 one or more times, then 58, then 16. Command 16 carries argument 0x00000200.
- R4: After each frame, up to 8 filler bytes are clocked. The first byte with bit 7 equal to 0 is taken as the response. If none of the 8 has bit 7 clear, `fail` is raised and no further command is sent.
- R5: If command 8 is answered with 0x01 followed by four bytes whose low 12 bits are 0x1AA, the card is treated as version 2 and command 41 carries argument 0x40000000. If command 8 is answered with 0x05, the card is treated as older and command 41 carries argument 0.
- R6: When command 41 is answered with 0x01, the pair 55/41 is sent again. Once `retry_limit` command-41 attempts have all been answered with 0x01, `fail` is raised, `done` stays low and command 58 is never sent. An answer of 0x00 on the last allowed attempt still succeeds.
- R7: `block_addr` equals bit 30 of the 32-bit register returned after command 58 (bit 6 of its first byte), ANDed with the version-2 decision. It holds steady while `done` is high.
- R8: `start` accepted in IDLE, DONE or FAIL gives a one-cycle `ready` pulse in the next cycle and clears `done` and `fail`. `done` stays high until the next `start`, and `done` and `fail` are never high together.
- R9: Chip select is high for one filler byte after each command's response. Chip select changes only while the serial clock is low.
- R10: A response byte that differs from the value expected for the step causes `fail`. The expected values are: 0x01 for command 0, 0x00 or 0x01 for command 55, and 0x00 for commands 58 and 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) the bring-up sequence |
| retry_limit | input | RETRY_W | Maximum number of command-41 attempts |
| ready | output | 1 | One-cycle acknowledge of an accepted `start` |
| done | output | 1 | Sequence finished successfully (held) |
| fail | output | 1 | Sequence aborted (held) |
| block_addr | output | 1 | Card uses block addressing |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low, mode 0 |
| spi_mosi | output | 1 | Serial data to the card |
| spi_miso | input | 1 | Serial data from the card |

## Verification
The bench uses a behavioural card model whose answers are set per scenario. Each setting isolates one behaviour:

- A high-capacity card with several idle answers shows the retry loop working and the command order.
- A byte-addressed card that answers at the last poll slot shows the polling window is inclusive.
- A card that answers one slot too late shows the timeout.
- An older card that rejects command 8 shows the argument change on command 41 and the masking of the addressing flag.
- A card that never leaves idle, and one that returns a wrong reset answer, show the retry budget and the response checks.
- A restart after a failure shows that the handshake flags are cleared and the sequence runs again from the start.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAKE,
        S_SEND,
        S_POLL,
        S_TRAIL,
        S_GAP,
        S_DONE,
        S_FAIL
    } state_t;

    typedef enum logic [2:0] {
        C_RESET,
        C_IFCOND,
        C_APPCMD,
        C_OPCOND,
        C_READOCR,
        C_BLKLEN,
        C_FINISH
    } step_t;

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [7:0]  crc;
    } cmd_t;

    localparam logic [7:0] FILL_BYTE      = 8'hFF;
    localparam logic [7:0] R1_READY       = 8'h00;
    localparam logic [7:0] R1_IDLE        = 8'h01;
    localparam logic [7:0] R1_IDLE_ILLCMD = 8'h05;
    localparam logic [11:0] IFCOND_ECHO   = 12'h1AA;

endpackage

// File: rtl/sdspi_byte_shift.sv
module sdspi_byte_shift #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx,
    output logic       busy,
    output logic       fin,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    localparam int DW = $clog2(HALF_DIV) + 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

    logic          busy_q, sclk_q, fin_q;
    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    tx_q, rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            fin_q  <= 1'b0;
            div_q  <= '0;
            bit_q  <= '0;
            tx_q   <= 8'hFF;
            rx_q   <= 8'hFF;
        end else begin
            fin_q <= 1'b0;
            if (!busy_q) begin
                if (go) begin
                    busy_q <= 1'b1;
                    tx_q   <= tx;
                    div_q  <= '0;
                    bit_q  <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_q   <= {rx_q[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    tx_q   <= {tx_q[6:0], 1'b1};
                    bit_q  <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        fin_q  <= 1'b1;
                    end
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    assign busy = busy_q;
    assign fin  = fin_q;
    assign rx   = rx_q;
    assign sclk = sclk_q;
    assign mosi = busy_q ? tx_q[7] : 1'b1;

endmodule

// File: rtl/sdspi_cmd_frame.sv
module sdspi_cmd_frame
    import sdspi_pkg::*;
(
    input  step_t      step,
    input  logic       hcs,
    input  logic [2:0] byte_idx,
    output logic [7:0] frame_byte
);
    cmd_t c;

    always_comb begin
        unique case (step)
            C_RESET:   c = '{idx: 6'd0,  arg: 32'h0000_0000, crc: 8'h95};
            C_IFCOND:  c = '{idx: 6'd8,  arg: 32'h0000_01AA, crc: 8'h87};
            C_APPCMD:  c = '{idx: 6'd55, arg: 32'h0000_0000, crc: 8'h01};
            C_OPCOND:  c = '{idx: 6'd41, arg: {1'b0, hcs, 30'd0}, crc: 8'h01};
            C_READOCR: c = '{idx: 6'd58, arg: 32'h0000_0000, crc: 8'h01};
            C_BLKLEN:  c = '{idx: 6'd16, arg: 32'h0000_0200, crc: 8'h01};
            default:   c = '{idx: 6'd0,  arg: 32'h0000_0000, crc: 8'hFF};
        endcase
    end

    always_comb begin
        unique case (byte_idx)
            3'd0:    frame_byte = {2'b01, c.idx};
            3'd1:    frame_byte = c.arg[31:24];
            3'd2:    frame_byte = c.arg[23:16];
            3'd3:    frame_byte = c.arg[15:8];
            3'd4:    frame_byte = c.arg[7:0];
            default: frame_byte = c.crc;
        endcase
    end

endmodule

// File: rtl/sdspi_init_seq.sv
module sdspi_init_seq
    import sdspi_pkg::*;
#(
    parameter int HALF_DIV  = 4,
    parameter int WAKE_CLKS = 74,
    parameter int RESP_POLL = 8,
    parameter int RETRY_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RETRY_W-1:0] retry_limit,
    output logic               ready,
    output logic               done,
    output logic               fail,
    output logic               block_addr,
    output logic               spi_cs_n,
    output logic               spi_sclk,
    output logic               spi_mosi,
    input  logic               spi_miso
);
    localparam int WAKE_BYTES  = (WAKE_CLKS + 7) / 8;
    localparam int FRAME_BYTES = 6;
    localparam int TRAIL_BYTES = 4;
    localparam int CNT_A       = (WAKE_BYTES > RESP_POLL) ? WAKE_BYTES : RESP_POLL;
    localparam int CNT_MAX     = (CNT_A > FRAME_BYTES) ? CNT_A : FRAME_BYTES;
    localparam int CW          = $clog2(CNT_MAX + 1);

    state_t             state_q, state_d;
    step_t              step_q, step_d;
    logic [CW-1:0]      cnt_q;
    logic [RETRY_W-1:0] tries_q;
    logic               hcs_q, blk_q, ready_q;
    logic [23:0]        trail_q;

    logic        x_go, x_busy, x_fin;
    logic [7:0]  x_tx, x_rx, frame_byte;
    logic [31:0] ocr_w;
    logic        rx_is_resp, last_try, accept, xfer_state;

    assign ocr_w      = {trail_q, x_rx};
    assign rx_is_resp = ~x_rx[7];
    assign last_try   = ({1'b0, tries_q} + (RETRY_W+1)'(1)) >= {1'b0, retry_limit};
    assign accept     = start && (state_q == S_IDLE || state_q == S_DONE || state_q == S_FAIL);

    sdspi_byte_shift #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (x_go),
        .tx   (x_tx),
        .busy (x_busy),
        .fin  (x_fin),
        .rx   (x_rx),
        .sclk (spi_sclk),
        .mosi (spi_mosi),
        .miso (spi_miso)
    );

    sdspi_cmd_frame u_frame (
        .step      (step_q),
        .hcs       (hcs_q),
        .byte_idx  (cnt_q[2:0]),
        .frame_byte(frame_byte)
    );

    // next-state and step selection
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) begin
                    state_d = S_WAKE;
                    step_d  = C_RESET;
                end
            end
            S_WAKE: begin
                if (x_fin && cnt_q == CW'(WAKE_BYTES - 1)) state_d = S_SEND;
            end
            S_SEND: begin
                if (x_fin && cnt_q == CW'(FRAME_BYTES - 1)) state_d = S_POLL;
            end
            S_POLL: begin
                if (x_fin) begin
                    if (rx_is_resp) begin
                        state_d = S_FAIL;
                        unique case (step_q)
                            C_RESET: if (x_rx == R1_IDLE) begin
                                state_d = S_GAP;
                                step_d  = C_IFCOND;
                            end
                            C_IFCOND: begin
                                if (x_rx == R1_IDLE) begin
                                    state_d = S_TRAIL;
                                end else if (x_rx == R1_IDLE_ILLCMD) begin
                                    state_d = S_GAP;
                                    step_d  = C_APPCMD;
                                end
                            end
                            C_APPCMD: if (x_rx[7:1] == 7'd0) begin
                                state_d = S_GAP;
                                step_d  = C_OPCOND;
                            end
                            C_OPCOND: begin
                                if (x_rx == R1_READY) begin
                                    state_d = S_GAP;
                                    step_d  = C_READOCR;
                                end else if (x_rx == R1_IDLE && !last_try) begin
                                    state_d = S_GAP;
                                    step_d  = C_APPCMD;
                                end
                            end
                            C_READOCR: if (x_rx == R1_READY) state_d = S_TRAIL;
                            C_BLKLEN: if (x_rx == R1_READY) begin
                                state_d = S_GAP;
                                step_d  = C_FINISH;
                            end
                            default: state_d = S_FAIL;
                        endcase
                    end else if (cnt_q == CW'(RESP_POLL - 1)) begin
                        state_d = S_FAIL;
                    end
                end
            end
            S_TRAIL: begin
                if (x_fin && cnt_q == CW'(TRAIL_BYTES - 1)) begin
                    state_d = S_FAIL;
                    if (step_q == C_IFCOND && ocr_w[11:0] == IFCOND_ECHO) begin
                        state_d = S_GAP;
                        step_d  = C_APPCMD;
                    end else if (step_q == C_READOCR) begin
                        state_d = S_GAP;
                        step_d  = C_BLKLEN;
                    end
                end
            end
            S_GAP: begin
                if (x_fin) state_d = (step_q == C_FINISH) ? S_DONE : S_SEND;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= C_RESET;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // counters and latched results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            tries_q <= '0;
            hcs_q   <= 1'b0;
            blk_q   <= 1'b0;
            ready_q <= 1'b0;
            trail_q <= '0;
        end else begin
            ready_q <= 1'b0;
            if (state_d != state_q) cnt_q <= '0;
            else if (x_fin)         cnt_q <= cnt_q + CW'(1);

            if (accept) begin
                ready_q <= 1'b1;
                hcs_q   <= 1'b0;
                blk_q   <= 1'b0;
                tries_q <= '0;
            end
            if (state_q == S_POLL && x_fin && rx_is_resp && step_q == C_OPCOND)
                tries_q <= tries_q + RETRY_W'(1);
            if (state_q == S_TRAIL && x_fin)
                trail_q <= {trail_q[15:0], x_rx};
            if (state_q == S_TRAIL && state_d == S_GAP && step_q == C_IFCOND)
                hcs_q <= 1'b1;
            if (state_q == S_TRAIL && state_d == S_GAP && step_q == C_READOCR)
                blk_q <= hcs_q & ocr_w[30];
        end
    end

    // outputs
    always_comb begin
        xfer_state = (state_q == S_WAKE) || (state_q == S_SEND) || (state_q == S_POLL) ||
                     (state_q == S_TRAIL) || (state_q == S_GAP);
        x_go       = xfer_state && !x_busy && !x_fin;
        x_tx       = (state_q == S_SEND) ? frame_byte : FILL_BYTE;
        spi_cs_n   = !((state_q == S_SEND) || (state_q == S_POLL) || (state_q == S_TRAIL));
        ready      = ready_q;
        done       = (state_q == S_DONE);
        fail       = (state_q == S_FAIL);
        block_addr = blk_q;
    end

endmodule

// File: rtl/sdspi_init_sva.sv
module sdspi_init_sva (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic ready,
    input logic done,
    input logic fail,
    input logic block_addr,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    p_mosi_high_when_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> spi_mosi);

    p_cs_moves_with_sclk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(spi_cs_n) || $fell(spi_cs_n)) |-> !spi_sclk);

    p_done_fail_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    p_ready_single_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    p_done_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_addr_flag_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(block_addr));

endmodule

bind sdspi_init_seq sdspi_init_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready     (ready),
    .done      (done),
    .fail      (fail),
    .block_addr(block_addr),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/sim_sdspi_init_seq.sv
`timescale 1ns/1ps
module sim_sdspi_init_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] retry_limit = 16'd3;
    logic        ready, done, fail, block_addr;
    logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int ready_cnt = 0;

    always #10 clk = ~clk;   // 50 MHz

    sdspi_init_seq #(.HALF_DIV(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .retry_limit(retry_limit),
        .ready(ready), .done(done), .fail(fail), .block_addr(block_addr),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ready) ready_cnt <= ready_cnt + 1;
    end

    // ---------------- card model ----------------
    logic        k_ver2 = 1'b1, k_ccs = 1'b1, k_cmd0_bad = 1'b0;
    int          k_idle_polls = 0, k_delay = 1;
    logic        model_clr = 1'b0;

    logic [7:0]  out_sh = 8'hFF;
    logic [7:0]  rxs = 8'hFF;
    logic [7:0]  frm [0:5];
    logic [7:0]  rq  [0:15];
    int          rq_len = 0, rq_pos = 0, fpos = 0, rx_bits = 0;
    logic        byte_end = 1'b0, p_sclk = 1'b0, p_cs = 1'b1, seen_low = 1'b0, card_idle = 1'b1;
    int          acmd_cnt = 0, wake_clks = 0, cs_rises = 0, log_n = 0;
    logic        wake_bad = 1'b0;
    int          log_idx [0:31];
    logic [31:0] log_arg [0:31];
    logic [7:0]  log_crc [0:31];

    assign spi_miso = out_sh[7];

    task automatic push(input logic [7:0] b);
        if (rq_len < 16) begin
            rq[rq_len] = b;
            rq_len++;
        end
    endtask

    task automatic handle_cmd();
        int idx;
        logic [31:0] arg;
        idx = int'(frm[0][5:0]);
        arg = {frm[1], frm[2], frm[3], frm[4]};
        if (log_n < 32) begin
            log_idx[log_n] = idx;
            log_arg[log_n] = arg;
            log_crc[log_n] = frm[5];
        end
        log_n++;
        rq_len = 0;
        rq_pos = 0;
        for (int i = 0; i < k_delay; i++) push(8'hFF);
        case (idx)
            0:  push(k_cmd0_bad ? 8'h00 : 8'h01);
            8:  if (k_ver2) begin
                    push(8'h01); push(8'h00); push(8'h00); push(8'h01); push(8'hAA);
                end else push(8'h05);
            55: push(card_idle ? 8'h01 : 8'h00);
            41: if (acmd_cnt < k_idle_polls) begin
                    acmd_cnt++;
                    push(8'h01);
                end else begin
                    card_idle = 1'b0;
                    push(8'h00);
                end
            58: begin
                    push(8'h00); push({1'b1, k_ccs, 6'd0}); push(8'hFF); push(8'h80); push(8'h00);
                end
            default: push(8'h00);
        endcase
    endtask

    task automatic got_byte(input logic [7:0] b);
        if (fpos == 0) begin
            if (b[7:6] == 2'b01) begin
                frm[0] = b;
                fpos = 1;
            end
        end else begin
            frm[fpos] = b;
            fpos++;
            if (fpos == 6) begin
                fpos = 0;
                handle_cmd();
            end
        end
    endtask

    always @(spi_sclk, spi_cs_n, model_clr) begin
        if (model_clr) begin
            out_sh = 8'hFF; rq_len = 0; rq_pos = 0; fpos = 0; rx_bits = 0;
            byte_end = 1'b0; seen_low = 1'b0; card_idle = 1'b1; acmd_cnt = 0;
            wake_clks = 0; wake_bad = 1'b0; cs_rises = 0; log_n = 0;
        end else begin
            if (spi_cs_n && !p_cs) begin
                cs_rises++; rx_bits = 0; fpos = 0; rq_len = 0; rq_pos = 0;
                out_sh = 8'hFF; byte_end = 1'b0;
            end
            if (!spi_cs_n && p_cs) seen_low = 1'b1;
            if (spi_sclk && !p_sclk) begin
                if (spi_cs_n) begin
                    if (!seen_low) begin
                        wake_clks++;
                        if (!spi_mosi) wake_bad = 1'b1;
                    end
                end else begin
                    rxs = {rxs[6:0], spi_mosi};
                    rx_bits++;
                    if (rx_bits == 8) begin
                        rx_bits = 0;
                        byte_end = 1'b1;
                        got_byte(rxs);
                    end
                end
            end
            if (!spi_sclk && p_sclk) begin
                if (byte_end) begin
                    byte_end = 1'b0;
                    if (rq_pos < rq_len) begin
                        out_sh = rq[rq_pos];
                        rq_pos++;
                    end else out_sh = 8'hFF;
                end else out_sh = {out_sh[6:0], 1'b1};
            end
        end
        p_sclk = spi_sclk;
        p_cs   = spi_cs_n;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input longint act, input longint exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic v2, input logic ccs, input int idle, input int dly,
                         input logic bad0, input logic [15:0] lim);
        k_ver2 = v2; k_ccs = ccs; k_idle_polls = idle; k_delay = dly;
        k_cmd0_bad = bad0; retry_limit = lim;
        model_clr = 1'b1;
        #1;
        model_clr = 1'b0;
    endtask

    task automatic launch_and_wait();
        int r0;
        bit ended;
        @(negedge clk);
        r0 = ready_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 ready pulse after start", ready, 1);
        chk("R8 flags cleared on start", {done, fail}, 0);
        @(negedge clk);
        chk("R8 ready one cycle", ready, 0);
        chk("R8 single ready count", ready_cnt - r0, 1);
        ended = 0;
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if (done || fail) begin
                ended = 1;
                break;
            end
        end
        chk("R8 sequence ended", ended, 1);
    endtask

    task automatic chk_seq(input string tag, input int exp_len, input int e0, input int e1,
                           input int pairs, input logic tail);
        int k;
        chk({tag, " count"}, log_n, exp_len);
        chk({tag, " cmd0 first"}, log_idx[0], e0);
        if (exp_len > 1) chk({tag, " cmd8 second"}, log_idx[1], e1);
        k = 2;
        for (int p = 0; p < pairs; p++) begin
            chk({tag, " app cmd"}, log_idx[k], 55);
            chk({tag, " op cond"}, log_idx[k+1], 41);
            k += 2;
        end
        if (tail) begin
            chk({tag, " ocr read"}, log_idx[k], 58);
            chk({tag, " blk len"}, log_idx[k+1], 16);
            chk("R3 block length arg", log_arg[k+1], 32'h200);
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R8 reset done", done, 0);
        chk("R8 reset fail", fail, 0);
        chk("R8 reset ready", ready, 0);
        chk("R9 reset cs", spi_cs_n, 1);
        chk("R9 reset sclk", spi_sclk, 0);
        chk("R1 reset mosi", spi_mosi, 1);
        chk("R7 reset block_addr", block_addr, 0);
    endtask

    task automatic t_v2_block();
        setup(1'b1, 1'b1, 2, 1, 1'b0, 16'd3);
        launch_and_wait();
        chk("R6 done on last allowed attempt", done, 1);
        chk("R6 no fail", fail, 0);
        chk("R7 block addressing", block_addr, 1);
        chk("R1 wake edges >= 74", wake_clks >= 74, 1);
        chk("R1 wake mosi high", wake_bad, 0);
        chk_seq("R3 v2", 10, 0, 8, 3, 1'b1);
        chk("R2 reset crc", log_crc[0], 8'h95);
        chk("R2 reset arg", log_arg[0], 0);
        chk("R2 ifcond arg", log_arg[1], 32'h1AA);
        chk("R2 ifcond crc", log_crc[1], 8'h87);
        chk("R5 v2 opcond arg", log_arg[3], 32'h4000_0000);
        chk("R9 cs released per command", cs_rises, 10);
        repeat (40) @(negedge clk);
        chk("R8 done held", done, 1);
        chk("R7 flag held", block_addr, 1);
    endtask

    task automatic t_v2_byte_late();
        setup(1'b1, 1'b0, 0, 7, 1'b0, 16'd1);
        launch_and_wait();
        chk("R4 response at 8th poll accepted", done, 1);
        chk("R7 byte addressing", block_addr, 0);
        chk_seq("R3 v2 immediate", 6, 0, 8, 1, 1'b1);
    endtask

    task automatic t_poll_miss();
        setup(1'b1, 1'b1, 0, 8, 1'b0, 16'd3);
        launch_and_wait();
        chk("R4 missing response fails", fail, 1);
        chk("R4 no done", done, 0);
        chk("R4 no further command", log_n, 1);
    endtask

    task automatic t_retry_limit();
        setup(1'b1, 1'b1, 1000, 1, 1'b0, 16'd3);
        launch_and_wait();
        chk("R6 retry exhausted fails", fail, 1);
        chk("R6 no done", done, 0);
        chk_seq("R6 retry", 8, 0, 8, 3, 1'b0);
    endtask

    task automatic t_old_card();
        setup(1'b0, 1'b1, 1, 2, 1'b0, 16'd4);
        launch_and_wait();
        chk("R5 older card done", done, 1);
        chk("R5 older card opcond arg", log_arg[3], 0);
        chk("R7 older card flag masked", block_addr, 0);
        chk_seq("R3 old", 8, 0, 8, 2, 1'b1);
    endtask

    task automatic t_bad_reset();
        setup(1'b1, 1'b1, 0, 1, 1'b1, 16'd3);
        launch_and_wait();
        chk("R10 wrong reset answer fails", fail, 1);
        chk("R10 stop after reset cmd", log_n, 1);
        chk("R7 flag clear after fail", block_addr, 0);
    endtask

    task automatic t_restart();
        setup(1'b1, 1'b1, 0, 0, 1'b0, 16'd2);
        launch_and_wait();
        chk("R8 restart after fail reaches done", done, 1);
        chk("R8 restart fail clear", fail, 0);
        chk("R7 restart flag", block_addr, 1);
        chk("R1 restart wake edges", wake_clks >= 74, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_v2_block();
        t_v2_byte_late();
        t_poll_miss();
        t_retry_limit();
        t_old_card();
        t_bad_reset();
        t_restart();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cyc >= 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule